// File: doc/BRIEF.md
# Lane Group Flow-Control Sequencer

This block steers one instruction stream that is shared by a group of SIMD lanes. It fetches one word per cycle from an external instruction memory through the program-counter port and decodes structured control opcodes: two-way branches, subroutine call and return, and counted loops. Each lane carries an active bit. When the lanes disagree on a branch condition, the group walks through both arms. Datapath writes are gated per lane by a write-enable mask, so each lane keeps only the results of the arm that its own condition picks. An arm that no lane wants is jumped over.

Three small LIFOs hold the saved lane masks, the return addresses and the remaining loop counts. Every control opcode holds issue for a fixed number of cycles. A count of retired instructions guards against runaway programs. Stack misuse, the instruction limit and an explicit end opcode each stop issue for good, and only reset restarts the sequencer.

Top module: `lane_branch_seq`

## Requirements
- R1: After reset, pc_o is 0, every lane is active, issue_o is low, wr_mask_o is zero, and done_o, err_o and timeout_o are low.
- R2: An instruction word is INSTR_W = 20 bits wide. The opcode sits in bits [19:16]: 0 datapath op, 1 IF, 2 ELSE, 3 ENDIF, 4 CALL, 5 RET, 6 LOOP, 7 ENDLOOP, 8 END, and codes 9 to 15 also count as datapath ops. Bits [15:0] hold a jump target (the low PC_W bits) or a loop count. A datapath op takes one cycle. On the edge that retires it, issue_o goes high for one cycle, with issue_pc_o set to its address and wr_mask_o set to the active lane mask. At every other time wr_mask_o is zero.
- R3: Every control opcode (codes 1 to 7) holds the program counter for CTRL_CYC = 2 cycles and takes effect on its last cycle. An IF/ENDIF pair therefore costs 4 cycles, IF/ELSE/ENDIF 6 cycles, CALL 2, RET 2 and LOOP/ENDLOOP 4. END takes one cycle.
- R4: IF pushes the active mask and ANDs it with cond_i, sampled on its final cycle. If the result is zero, the next pc is the target, otherwise pc+1. A datapath op is never issued with an all-zero mask.
- R5: ELSE sets the active mask to the saved mask AND NOT the current mask, and jumps to its target if the result is zero. ENDIF pops the saved mask back into the active mask.
- R6: CALL pushes pc+1 and jumps to the target. RET pops the saved address into pc.
- R7: LOOP pushes the count from bits [15:0]. ENDLOOP jumps to its target and decrements the count while the count is above 1. Otherwise it pops and falls through, so counts 0 and 1 both run the body once.
- R8: A push to a full stack (STK_DEPTH = 4) or a pop from an empty stack raises err_o. The offending instruction has no effect, err_o stays high, and pc_o freezes with no further issue.
- R9: When the number of retired instructions reaches DYN_LIMIT, timeout_o rises and stays high, and issue stops with pc_o frozen.
- R10: END raises done_o and halts issue with pc_o frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 20 | Instruction word at address pc_o |
| cond_i | input | LANES | Per-lane branch condition for the instruction at pc_o |
| pc_o | output | PC_W | Registered fetch address |
| issue_o | output | 1 | Datapath op issued this cycle |
| issue_pc_o | output | PC_W | Address of the issued op |
| wr_mask_o | output | LANES | Per-lane register write enable |
| done_o | output | 1 | END reached |
| err_o | output | 1 | Sticky stack overflow or underflow |
| timeout_o | output | 1 | Sticky instruction-limit flag |

## Verification
A datapath op presented on pc_o produces its issue_o, issue_pc_o and wr_mask_o on the very next clock edge. A control opcode changes pc_o only after its second edge. A halting flag rises on the edge that retires END, the faulty control opcode, or the instruction that reaches the limit. The bench samples every output at the falling edge after each rising edge. It counts edges from reset release until a halting flag appears, and compares that count with the cycle budget that a bench-side interpreter sums from the per-opcode costs. The issue trace, with addresses and masks, is matched entry by entry against the trace from the same interpreter.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam int INSTR_W = 20;
  localparam int IMM_W   = 16;
  localparam int OPC_LSB = 16;

  localparam logic [3:0] OPC_ALU     = 4'd0;
  localparam logic [3:0] OPC_IF      = 4'd1;
  localparam logic [3:0] OPC_ELSE    = 4'd2;
  localparam logic [3:0] OPC_ENDIF   = 4'd3;
  localparam logic [3:0] OPC_CALL    = 4'd4;
  localparam logic [3:0] OPC_RET     = 4'd5;
  localparam logic [3:0] OPC_LOOP    = 4'd6;
  localparam logic [3:0] OPC_ENDLOOP = 4'd7;
  localparam logic [3:0] OPC_END     = 4'd8;

  function automatic logic opc_is_ctrl(input logic [3:0] opc);
    return (opc >= OPC_IF) && (opc <= OPC_ENDLOOP);
  endfunction
endpackage

// File: rtl/lbs_lifo.sv
module lbs_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic         wr_top_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] cnt_q;
  logic [AW-1:0] top_idx;

  assign top_idx = AW'(cnt_q - PW'(1));
  assign top_o   = mem[top_idx];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == PW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push_i) begin
      cnt_q <= cnt_q + PW'(1);
    end else if (pop_i) begin
      cnt_q <= cnt_q - PW'(1);
    end
  end

  // storage without reset so it can map onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (push_i) begin
      mem[AW'(cnt_q)] <= din_i;
    end else if (wr_top_i) begin
      mem[top_idx] <= din_i;
    end
  end

  a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o);
  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (pop_i || wr_top_i) |-> !empty_o);
endmodule

// File: rtl/lbs_dyn_cnt.sv
module lbs_dyn_cnt #(
  parameter int LIMIT = 65535
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic last_o
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  assign last_o = tick_i && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  // the sequencer must stop retiring once the limit is hit
  a_r9_no_tick_past_limit: assert property (@(posedge clk) disable iff (rst)
    tick_i |-> (cnt_q < W'(LIMIT)));
endmodule

// File: rtl/lane_branch_seq.sv
module lane_branch_seq
  import lbs_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int PC_W      = 8,
  parameter int STK_DEPTH = 4,
  parameter int CTRL_CYC  = 2,
  parameter int DYN_LIMIT = 65535
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [19:0]        instr_i,
  input  logic [LANES-1:0]   cond_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               issue_o,
  output logic [PC_W-1:0]    issue_pc_o,
  output logic [LANES-1:0]   wr_mask_o,
  output logic               done_o,
  output logic               err_o,
  output logic               timeout_o
);
  localparam int WW = $clog2(CTRL_CYC + 1);

  logic [PC_W-1:0]  pc_q, ipc_q, pc_inc, nxt_pc, tgt;
  logic [LANES-1:0] act_q, nxt_act, wrm_q;
  logic [WW-1:0]    wait_q;
  logic             err_q, tmo_q, done_q, issue_q;
  logic [3:0]       opc;
  logic [IMM_W-1:0] imm;
  logic             is_ctrl, is_alu, run, fire, bad, go, dyn_last;

  logic             m_push, m_pop, m_empty, m_full;
  logic [LANES-1:0] m_top;
  logic             c_push, c_pop, c_empty, c_full;
  logic [PC_W-1:0]  c_top;
  logic             l_push, l_pop, l_wr, l_empty, l_full;
  logic [IMM_W-1:0] l_top, l_din;

  assign opc     = instr_i[OPC_LSB +: 4];
  assign imm     = instr_i[IMM_W-1:0];
  assign tgt     = imm[PC_W-1:0];
  assign is_ctrl = opc_is_ctrl(opc);
  assign is_alu  = !is_ctrl && (opc != OPC_END);
  assign pc_inc  = pc_q + PC_W'(1);
  assign run     = !(err_q || tmo_q || done_q);
  assign fire    = run && (!is_ctrl || (wait_q == WW'(CTRL_CYC - 1)));
  assign go      = fire && !bad;

  always_comb begin
    nxt_pc  = pc_inc;
    nxt_act = act_q;
    bad     = 1'b0;
    m_push  = 1'b0;
    m_pop   = 1'b0;
    c_push  = 1'b0;
    c_pop   = 1'b0;
    l_push  = 1'b0;
    l_pop   = 1'b0;
    l_wr    = 1'b0;
    l_din   = imm;
    case (opc)
      OPC_IF: begin
        bad     = m_full;
        m_push  = 1'b1;
        nxt_act = act_q & cond_i;
        if (nxt_act == '0) nxt_pc = tgt;
      end
      OPC_ELSE: begin
        bad     = m_empty;
        nxt_act = m_top & ~act_q;
        if (nxt_act == '0) nxt_pc = tgt;
      end
      OPC_ENDIF: begin
        bad     = m_empty;
        m_pop   = 1'b1;
        nxt_act = m_top;
      end
      OPC_CALL: begin
        bad    = c_full;
        c_push = 1'b1;
        nxt_pc = tgt;
      end
      OPC_RET: begin
        bad    = c_empty;
        c_pop  = 1'b1;
        nxt_pc = c_top;
      end
      OPC_LOOP: begin
        bad    = l_full;
        l_push = 1'b1;
      end
      OPC_ENDLOOP: begin
        bad = l_empty;
        if (l_top > IMM_W'(1)) begin
          l_wr   = 1'b1;
          l_din  = l_top - IMM_W'(1);
          nxt_pc = tgt;
        end else begin
          l_pop = 1'b1;
        end
      end
      OPC_END: nxt_pc = pc_q;
      default: ;
    endcase
  end

  lbs_lifo #(.W(LANES), .DEPTH(STK_DEPTH)) u_mask_stk (
    .clk(clk), .rst(rst), .push_i(go && m_push), .pop_i(go && m_pop),
    .wr_top_i(1'b0), .din_i(act_q), .top_o(m_top),
    .empty_o(m_empty), .full_o(m_full));

  lbs_lifo #(.W(PC_W), .DEPTH(STK_DEPTH)) u_call_stk (
    .clk(clk), .rst(rst), .push_i(go && c_push), .pop_i(go && c_pop),
    .wr_top_i(1'b0), .din_i(pc_inc), .top_o(c_top),
    .empty_o(c_empty), .full_o(c_full));

  lbs_lifo #(.W(IMM_W), .DEPTH(STK_DEPTH)) u_loop_stk (
    .clk(clk), .rst(rst), .push_i(go && l_push), .pop_i(go && l_pop),
    .wr_top_i(go && l_wr), .din_i(l_din), .top_o(l_top),
    .empty_o(l_empty), .full_o(l_full));

  lbs_dyn_cnt #(.LIMIT(DYN_LIMIT)) u_dyn (
    .clk(clk), .rst(rst), .tick_i(go && (opc != OPC_END)), .last_o(dyn_last));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      act_q   <= '1;
      wait_q  <= '0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
      done_q  <= 1'b0;
      issue_q <= 1'b0;
      wrm_q   <= '0;
      ipc_q   <= '0;
    end else begin
      issue_q <= 1'b0;
      wrm_q   <= '0;
      if (run && is_ctrl && !fire) wait_q <= wait_q + WW'(1);
      else                         wait_q <= '0;
      if (fire) begin
        if (bad) begin
          err_q <= 1'b1;
        end else begin
          pc_q  <= nxt_pc;
          act_q <= nxt_act;
          if (opc == OPC_END) done_q <= 1'b1;
          if (dyn_last) tmo_q <= 1'b1;
          if (is_alu) begin
            issue_q <= 1'b1;
            wrm_q   <= act_q;
            ipc_q   <= pc_q;
          end
        end
      end
    end
  end

  assign pc_o       = pc_q;
  assign issue_o    = issue_q;
  assign issue_pc_o = ipc_q;
  assign wr_mask_o  = wrm_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign timeout_o  = tmo_q;

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  a_r8_err_halts: assert property (@(posedge clk) disable iff (rst)
    err_o |=> ($stable(pc_o) && !issue_o));
  a_r9_timeout_halts: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> (timeout_o && $stable(pc_o) && !issue_o));
  a_r10_done_halts: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o && $stable(pc_o) && !issue_o));
  a_r4_no_empty_issue: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> (wr_mask_o != '0));
  a_r2_mask_only_on_issue: assert property (@(posedge clk) disable iff (rst)
    !issue_o |-> (wr_mask_o == '0));

  generate
    if (CTRL_CYC > 1) begin : g_stall_chk
      a_r3_ctrl_holds_pc: assert property (@(posedge clk) disable iff (rst)
        (run && is_ctrl && (wait_q == '0)) |=> $stable(pc_o));
    end
  endgenerate
endmodule

// File: tb/lane_branch_seq_tb_top.sv
module lane_branch_seq_tb_top;
  localparam int LANES = 16;
  localparam int PC_W  = 8;
  localparam int CC    = 2;
  localparam int DYN   = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [19:0]      prog     [0:31];
  logic [15:0]      cond_tab [0:31];
  logic [19:0]      instr;
  logic [LANES-1:0] cond;
  logic [PC_W-1:0]  pc, ipc;
  logic [LANES-1:0] wmask;
  logic             issue, done, err, tmo;

  assign instr = prog[pc[4:0]];
  assign cond  = cond_tab[pc[4:0]];

  lane_branch_seq #(.LANES(LANES), .PC_W(PC_W), .STK_DEPTH(4),
                    .CTRL_CYC(CC), .DYN_LIMIT(DYN)) dut_i (
    .clk(clk), .rst(rst), .instr_i(instr), .cond_i(cond), .pc_o(pc),
    .issue_o(issue), .issue_pc_o(ipc), .wr_mask_o(wmask),
    .done_o(done), .err_o(err), .timeout_o(tmo));

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] ins(input int op, input int imm);
    return {op[3:0], imm[15:0]};
  endfunction

  int          exp_pc   [0:255];
  logic [15:0] exp_mask [0:255];
  int          exp_n, exp_cyc;
  bit          exp_done, exp_err, exp_tmo;

  // instruction-level interpreter built from the requirements
  task automatic model();
    int pc_m = 0, msp = 0, csp = 0, lsp = 0, ret = 0;
    logic [15:0] act = 16'hFFFF;
    logic [15:0] ms [4];
    int cs [4];
    int ls [4];
    logic [3:0] op;
    int imm;
    bit stop = 0;
    exp_n = 0; exp_cyc = 0; exp_done = 0; exp_err = 0; exp_tmo = 0;
    for (int s = 0; s < 4000 && !stop; s++) begin
      op  = prog[pc_m % 32][19:16];
      imm = int'(prog[pc_m % 32][15:0]);
      exp_cyc += (op >= 1 && op <= 7) ? CC : 1;
      case (op)
        4'd1: if (msp == 4) exp_err = 1; else begin
                ms[msp] = act; msp++; act = act & cond_tab[pc_m % 32];
                pc_m = (act == 0) ? imm : pc_m + 1; end
        4'd2: if (msp == 0) exp_err = 1; else begin
                act = ms[msp-1] & ~act; pc_m = (act == 0) ? imm : pc_m + 1; end
        4'd3: if (msp == 0) exp_err = 1; else begin
                msp--; act = ms[msp]; pc_m++; end
        4'd4: if (csp == 4) exp_err = 1; else begin
                cs[csp] = pc_m + 1; csp++; pc_m = imm; end
        4'd5: if (csp == 0) exp_err = 1; else begin
                csp--; pc_m = cs[csp]; end
        4'd6: if (lsp == 4) exp_err = 1; else begin
                ls[lsp] = imm; lsp++; pc_m++; end
        4'd7: if (lsp == 0) exp_err = 1;
              else if (ls[lsp-1] > 1) begin ls[lsp-1]--; pc_m = imm; end
              else begin lsp--; pc_m++; end
        4'd8: exp_done = 1;
        default: begin
          if (exp_n < 256) begin exp_pc[exp_n] = pc_m; exp_mask[exp_n] = act; end
          exp_n++; pc_m++;
        end
      endcase
      if (exp_err || exp_done) stop = 1;
      else begin
        ret++;
        if (ret == DYN) begin exp_tmo = 1; stop = 1; end
      end
    end
  endtask

  int          got_n;
  int          got_pc   [0:255];
  logic [15:0] got_mask [0:255];

  task automatic run_and_check(input string tag);
    int k = 0;
    logic [PC_W-1:0] hold_pc;
    model();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pc == 0 && !issue && wmask == 0 && !done && !err && !tmo,
        "R1", "reset state", {pc, issue, wmask, done, err, tmo}, 0);
    rst = 1'b0;
    got_n = 0;
    for (int i = 0; i < exp_cyc + 20; i++) begin
      @(posedge clk); @(negedge clk);
      k++;
      if (issue) begin
        if (got_n < 256) begin got_pc[got_n] = int'(ipc); got_mask[got_n] = wmask; end
        got_n++;
      end
      if (done || err || tmo) break;
    end
    chk(k == exp_cyc, "R3", {tag, " cycles to halt"}, k, exp_cyc);
    chk(done == exp_done, "R10", {tag, " done flag"}, done, exp_done);
    chk(err == exp_err, "R8", {tag, " err flag"}, err, exp_err);
    chk(tmo == exp_tmo, "R9", {tag, " timeout flag"}, tmo, exp_tmo);
    chk(got_n == exp_n, "R2", {tag, " issue count"}, got_n, exp_n);
    for (int i = 0; i < got_n && i < exp_n && i < 256; i++) begin
      chk(got_pc[i] == exp_pc[i], "R2/R6/R7", {tag, " issue pc"}, got_pc[i], exp_pc[i]);
      chk(got_mask[i] == exp_mask[i], "R4/R5", {tag, " write mask"}, got_mask[i], exp_mask[i]);
    end
    hold_pc = pc;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk(pc == hold_pc && !issue, "R8/R9/R10", {tag, " halted"}, {pc, issue}, {hold_pc, 1'b0});
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) begin prog[i] = ins(8, 0); cond_tab[i] = 16'hFFFF; end
  endtask

  task automatic load_main(input int loops);
    clear_prog();
    prog[0]  = ins(0, 0);
    prog[1]  = ins(1, 5);       // IF -> ELSE at 5
    prog[2]  = ins(0, 0);
    prog[3]  = ins(4, 12);      // CALL 12
    prog[4]  = ins(9, 0);       // code 9 acts as datapath op
    prog[5]  = ins(2, 9);       // ELSE -> ENDIF at 9
    prog[6]  = ins(6, loops);   // LOOP
    prog[7]  = ins(0, 0);
    prog[8]  = ins(7, 7);       // ENDLOOP -> 7
    prog[9]  = ins(3, 0);       // ENDIF
    prog[10] = ins(0, 0);
    prog[11] = ins(8, 0);       // END
    prog[12] = ins(1, 14);      // nested IF -> ENDIF at 14
    prog[13] = ins(0, 0);
    prog[14] = ins(3, 0);
    prog[15] = ins(5, 0);       // RET
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed: all lanes take the if-arm, loop count 3
    load_main(3); cond_tab[1] = 16'hFFFF; cond_tab[12] = 16'h00F0;
    run_and_check("R4 all-true");
    // directed: no lane takes the if-arm, loop count 0 runs once (R7)
    load_main(0); cond_tab[1] = 16'h0000;
    run_and_check("R5/R7 all-false");
    // directed: split lanes, inner IF skipped
    load_main(1); cond_tab[1] = 16'hA5A5; cond_tab[12] = 16'h5A5A;
    run_and_check("R5 divergent");
    // constrained random conditions and loop counts
    for (int r = 0; r < 12; r++) begin
      int sel;
      load_main(int'($urandom % 5));
      sel = int'($urandom % 4);
      cond_tab[1]  = (sel == 0) ? 16'h0 : (sel == 1) ? 16'hFFFF : 16'($urandom);
      cond_tab[12] = ($urandom % 3 == 0) ? 16'h0 : 16'($urandom);
      run_and_check("R4/R6/R7 random");
    end
    // mask stack overflow: five nested IFs
    clear_prog();
    for (int i = 0; i < 5; i++) prog[i] = ins(1, 20);
    run_and_check("R8 mask overflow");
    // call stack overflow: recursive CALL
    clear_prog(); prog[0] = ins(0, 0); prog[1] = ins(4, 1);
    run_and_check("R8 call overflow");
    // underflows
    clear_prog(); prog[0] = ins(5, 0);
    run_and_check("R8 ret underflow");
    clear_prog(); prog[0] = ins(0, 0); prog[1] = ins(3, 0);
    run_and_check("R8 endif underflow");
    // runaway loop hits the instruction limit
    clear_prog(); prog[0] = ins(6, 16'hFFFF); prog[1] = ins(0, 0); prog[2] = ins(7, 1);
    run_and_check("R9 limit");
    chk(got_n == DYN / 2, "R9", "ops issued before limit", got_n, DYN / 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule